// File: doc/BRIEF.md
# Reset Sequencer with Bidirectional Pin Timing

This block gathers reset requests from six causes and turns each one into a fixed sequence on an open-drain reset pin. The causes are power-up, supply brown-out, an external pull on the reset pin, an illegal address access, a clock monitor failure and a watchdog time-out. The sequence runs on the clock that is active while the chip is in reset. For a set number of cycles the block pulls the pin low. It then lets the pin go and waits a further set number of cycles. At that point it looks at the pin level through a two-stage synchronizer. The internal reset to the rest of the chip stays asserted for the whole sequence. It stays asserted longer if some outside agent is still pulling the pin low.

The causes that arrive during a sequence are kept as flags. When the sequence ends, the block turns the flags into a vector class code, registers the code, and clears the flags. A new request that arrives in the middle of a sequence starts the timing again from zero. The new cause is added to the flags already held.

Top module: `rst_sequencer`

## Requirements
- R1: Every reset request enables the pin pull-down (`pin_drive_en` = 1) for exactly DRIVE_CYC cycles, which is 512 by default.
- R2: After the pull-down ends, the pin is released for SAMPLE_CYC cycles, which is 256 by default. The pin level is judged at the end of that window. If the pin is then high, `int_rst` has been high for exactly DRIVE_CYC + SAMPLE_CYC cycles (768).
- R3: `int_rst` is high whenever the pin is pulled down. `int_rst`, `pin_drive_en` and power-class vector 0 are all active while `rst_n` is low. A full power-class sequence follows the release of `rst_n`.
- R4: If the synchronized pin is still low at the end of the release window, `int_rst` stays high until the synchronized pin reads high. That cause is recorded as an external-pin cause.
- R5: If the pin is pulled low from outside while no sequence runs, a full sequence starts with the external-pin cause recorded.
- R6: A new cause strobe during a sequence restarts it. A full DRIVE_CYC pull-down and a full DRIVE_CYC + SAMPLE_CYC reset then follow.
- R7: `vec_sel` is chosen by priority. Code 0 means power-up or brown-out is pending. Otherwise code 1 means an external-pin cause. Otherwise code 2 means clock monitor failure. Otherwise code 3 means watchdog. Otherwise code 4, which is used for illegal address.
- R8: Cause flags are cleared when a sequence ends, so the next sequence's code reflects only its own causes.
- R9: `vec_sel` changes only at the end of a sequence and holds its value while `int_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reset-time sequencing clock |
| rst_n | input | 1 | Synchronous active-low base reset (acts as power-up) |
| por_req | input | 1 | Power-up request strobe |
| lvr_req | input | 1 | Brown-out request strobe |
| illaddr_req | input | 1 | Illegal address request strobe |
| clkmon_req | input | 1 | Clock monitor failure strobe |
| wdog_req | input | 1 | Watchdog time-out strobe |
| pin_in | input | 1 | Level read back from the reset pin |
| pin_drive_en | output | 1 | Enables the open-drain pull-down on the pin |
| int_rst | output | 1 | Internal reset to the rest of the chip |
| vec_sel | output | 3 | Vector class code registered at sequence end |

## Verification
The hardest case to reach is an outside agent that keeps holding the pin low after the block has let go. The pin has to read low exactly when the release window closes, and then rise at a known cycle so that the extension can be counted. The bench models the pin as a wired-AND of the block's pull-down and a bench-owned hold signal. It keeps the hold asserted across the whole sequence and drops it at a chosen cycle count. It then checks the exact extension through the two-stage synchronizer and the external-pin code. Restarts use the same cycle counting: a second strobe lands mid-sequence, and the bench times the full sequence again from that point.

// File: rtl/rstgen_pkg.sv
// Shared types for the reset sequencer: state encoding, vector codes,
// cause flag record and the vector priority function.
package rstgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRIVE   = 2'd1,
        ST_RELEASE = 2'd2,
        ST_HOLD    = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        VEC_POWER   = 3'd0,
        VEC_PIN     = 3'd1,
        VEC_CLKMON  = 3'd2,
        VEC_WDOG    = 3'd3,
        VEC_ILLADDR = 3'd4
    } vec_code_e;

    typedef struct packed {
        logic power;
        logic pin;
        logic clkmon;
        logic wdog;
        logic illaddr;
    } cause_t;

    // Priority: power class, then pin, clock monitor, watchdog, illegal address.
    function automatic vec_code_e pick_vector(input cause_t c);
        if (c.power)       return VEC_POWER;
        else if (c.pin)    return VEC_PIN;
        else if (c.clkmon) return VEC_CLKMON;
        else if (c.wdog)   return VEC_WDOG;
        else               return VEC_ILLADDR;
    endfunction

endpackage

// File: rtl/rstgen_pin_sync.sv
// Multi-stage synchronizer for the reset pin read-back.
// Assumes the pin idles high; all stages reset to 1 so no spurious
// low is seen after base reset.
module rstgen_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the flop chain.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= pin_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rstgen_seq_fsm.sv
// Pin sequencing state machine: pull-down phase, release phase, sample,
// optional wait for the pin to rise. Restarts on any new request.
// Assumes pin_lvl is already synchronized to clk.
module rstgen_seq_fsm
    import rstgen_pkg::*;
#(
    parameter int DRIVE_CYC  = 512,
    parameter int SAMPLE_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic new_req,
    input  logic pin_lvl,
    output logic drive_en,
    output logic busy,
    output logic pin_evt,
    output logic done
);
    localparam int MAX_CYC = (DRIVE_CYC > SAMPLE_CYC) ? DRIVE_CYC : SAMPLE_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_CYC - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);

    seq_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             idle_low, sample_low;

    // Next-state and phase counter logic.
    always_comb begin
        state_n    = state_q;
        cnt_n      = cnt_q;
        done       = 1'b0;
        sample_low = 1'b0;
        idle_low   = (state_q == ST_IDLE) && !pin_lvl;
        if (new_req || idle_low) begin
            state_n = ST_DRIVE;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                ST_DRIVE: begin
                    if (cnt_q == DRIVE_LAST) begin
                        state_n = ST_RELEASE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_RELEASE: begin
                    if (cnt_q == SAMPLE_LAST) begin
                        cnt_n = '0;
                        if (!pin_lvl) begin
                            state_n    = ST_HOLD;
                            sample_low = 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                            done    = 1'b1;
                        end
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (pin_lvl) begin
                        state_n = ST_IDLE;
                        done    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // State and counter registers; base reset starts a full sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DRIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign drive_en = (state_q == ST_DRIVE);
    assign busy     = (state_q != ST_IDLE);
    assign pin_evt  = idle_low | sample_low;

    // R4: while waiting for the pin, a low pin keeps the block waiting.
    a_r4_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !pin_lvl && !new_req) |=> (state_q == ST_HOLD));

    // R2: the wait state is entered only from the release phase.
    a_r2_hold_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_HOLD) |-> ($past(state_q) == ST_RELEASE));

    // R1: the drive phase is always followed by release or a restart.
    a_r1_drive_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && cnt_q == DRIVE_LAST && !new_req) |=> (state_q == ST_RELEASE));

endmodule

// File: rtl/rstgen_cause_latch.sv
// Holds pending reset causes for the running sequence and registers the
// vector class code when the sequence ends, clearing the causes.
// Assumes done is never raised in a cycle that carries a new cause.
module rstgen_cause_latch
    import rstgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cause_t     cause_in,
    input  logic       done,
    output logic [2:0] vec_code,
    output logic       flags_empty
);
    cause_t    flags_q;
    vec_code_e vec_q;

    // Accumulate causes; clear at sequence end. Base reset counts as power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q       <= '0;
            flags_q.power <= 1'b1;
        end else if (done) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_q | cause_in;
        end
    end

    // Register the vector class at sequence end.
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_q <= VEC_POWER;
        else if (done) vec_q <= pick_vector(flags_q);
    end

    assign vec_code    = vec_q;
    assign flags_empty = (flags_q == '0);

endmodule

// File: rtl/rst_sequencer.sv
// Reset sequencer top: merges cause strobes, runs the pin sequence,
// holds the internal reset and publishes the vector class code.
// Assumes all strobes are synchronous single-cycle pulses on clk.
module rst_sequencer
    import rstgen_pkg::*;
#(
    parameter int DRIVE_CYC   = 512,
    parameter int SAMPLE_CYC  = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_req,
    input  logic       lvr_req,
    input  logic       illaddr_req,
    input  logic       clkmon_req,
    input  logic       wdog_req,
    input  logic       pin_in,
    output logic       pin_drive_en,
    output logic       int_rst,
    output logic [2:0] vec_sel
);
    logic   pin_sync, any_strobe, pin_evt, seq_done, flags_empty;
    cause_t causes;

    assign any_strobe = por_req | lvr_req | illaddr_req | clkmon_req | wdog_req;

    // Gather this cycle's causes into one record.
    always_comb begin
        causes         = '0;
        causes.power   = por_req | lvr_req;
        causes.pin     = pin_evt;
        causes.clkmon  = clkmon_req;
        causes.wdog    = wdog_req;
        causes.illaddr = illaddr_req;
    end

    rstgen_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (pin_sync)
    );

    rstgen_seq_fsm #(.DRIVE_CYC(DRIVE_CYC), .SAMPLE_CYC(SAMPLE_CYC)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .new_req  (any_strobe),
        .pin_lvl  (pin_sync),
        .drive_en (pin_drive_en),
        .busy     (int_rst),
        .pin_evt  (pin_evt),
        .done     (seq_done)
    );

    rstgen_cause_latch latch_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cause_in    (causes),
        .done        (seq_done),
        .vec_code    (vec_sel),
        .flags_empty (flags_empty)
    );

    // R3: pulling the pin always comes with internal reset.
    a_r3_drive_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_en |-> int_rst);

    // R6: a strobe during a sequence puts the block back into pull-down.
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rst && any_strobe) |=> pin_drive_en);

    // R5: a low synchronized pin while idle launches a sequence.
    a_r5_idle_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_rst && !pin_sync) |=> int_rst);

    // R8: no cause is pending while the chip is out of reset.
    a_r8_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !int_rst |-> flags_empty);

    // R9: vector code is steady between sequences.
    a_r9_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_rst && !$past(int_rst)) |-> $stable(vec_sel));

endmodule

// File: tb/rst_sequencer_tb_top.sv
// Directed bench for the reset sequencer; one task per scenario.
module rst_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DRV = 512;
    localparam int SMP = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_req = 0, lvr_req = 0, illaddr_req = 0, clkmon_req = 0, wdog_req = 0;
    logic ext_hold = 1'b0;
    logic pin_in, pin_drive_en, int_rst;
    logic [2:0] vec_sel;

    int checks = 0;
    int errors = 0;
    int drv_cnt, rst_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Wired-AND pin: pulled low by the block or by an outside agent.
    assign pin_in = !(pin_drive_en || ext_hold);

    rst_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .lvr_req(lvr_req),
        .illaddr_req(illaddr_req), .clkmon_req(clkmon_req), .wdog_req(wdog_req),
        .pin_in(pin_in), .pin_drive_en(pin_drive_en), .int_rst(int_rst),
        .vec_sel(vec_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse strobes for one cycle; returns at the negedge after capture.
    task automatic pulse(input bit p, input bit l, input bit ia, input bit cm, input bit wd);
        @(negedge clk);
        por_req = p; lvr_req = l; illaddr_req = ia; clkmon_req = cm; wdog_req = wd;
        @(negedge clk);
        por_req = 0; lvr_req = 0; illaddr_req = 0; clkmon_req = 0; wdog_req = 0;
    endtask

    // Count samples with drive/reset high from the current negedge on;
    // drops ext_hold when the reset count reaches hold_until (0 = never).
    task automatic measure(input int hold_until);
        drv_cnt = 0; rst_cnt = 0;
        for (int i = 0; i < 5000; i++) begin
            if (!int_rst) break;
            rst_cnt++;
            if (pin_drive_en) drv_cnt++;
            if (hold_until != 0 && rst_cnt == hold_until) ext_hold = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(int_rst == 1'b1, "R3 int_rst in reset", int'(int_rst), 1);
        check(pin_drive_en == 1'b1, "R3 drive in reset", int'(pin_drive_en), 1);
        check(vec_sel == 3'd0, "R3 vector in reset", int'(vec_sel), 0);
        rst_n = 1'b1;
        measure(0);
        check(drv_cnt == DRV, "R1 power-up drive length", drv_cnt, DRV);
        check(rst_cnt == DRV + SMP, "R2 power-up reset length", rst_cnt, DRV + SMP);
        check(vec_sel == 3'd0, "R7 power vector", int'(vec_sel), 0);
    endtask

    task automatic t_watchdog();
        pulse(0, 0, 0, 0, 1);
        measure(0);
        check(drv_cnt == DRV, "R1 watchdog drive length", drv_cnt, DRV);
        check(rst_cnt == DRV + SMP, "R2 watchdog reset length", rst_cnt, DRV + SMP);
        check(vec_sel == 3'd3, "R7 watchdog vector", int'(vec_sel), 3);
    endtask

    task automatic t_restart();
        pulse(0, 0, 0, 0, 1);
        repeat (300) @(negedge clk);
        pulse(0, 0, 0, 1, 0);
        measure(0);
        check(drv_cnt == DRV, "R6 restarted drive length", drv_cnt, DRV);
        check(rst_cnt == DRV + SMP, "R6 restarted reset length", rst_cnt, DRV + SMP);
        check(vec_sel == 3'd2, "R7 clkmon over watchdog", int'(vec_sel), 2);
    endtask

    task automatic t_flags_cleared();
        pulse(0, 0, 0, 0, 1);
        measure(0);
        check(vec_sel == 3'd3, "R8 old clkmon cause cleared", int'(vec_sel), 3);
    endtask

    task automatic t_power_priority();
        pulse(0, 1, 1, 1, 1);
        measure(0);
        check(vec_sel == 3'd0, "R7 brown-out wins", int'(vec_sel), 0);
        pulse(0, 0, 1, 0, 0);
        measure(0);
        check(vec_sel == 3'd4, "R7 illegal address vector", int'(vec_sel), 4);
    endtask

    task automatic t_vec_hold();
        repeat (40) @(negedge clk);
        check(int_rst == 1'b0, "R9 idle stays out of reset", int'(int_rst), 0);
        check(vec_sel == 3'd4, "R9 vector held while idle", int'(vec_sel), 4);
    endtask

    task automatic t_external_extend();
        pulse(0, 0, 1, 0, 0);
        ext_hold = 1'b1;
        measure(1000);
        check(rst_cnt == 1002, "R4 extended reset length", rst_cnt, 1002);
        check(drv_cnt == DRV, "R4 drive length unchanged", drv_cnt, DRV);
        check(vec_sel == 3'd1, "R4 external pin vector", int'(vec_sel), 1);
    endtask

    task automatic t_idle_pin();
        @(negedge clk);
        ext_hold = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (int_rst) break;
            @(negedge clk);
        end
        check(int_rst == 1'b1, "R5 pin pull starts sequence", int'(int_rst), 1);
        measure(50);
        check(rst_cnt == DRV + SMP, "R5 pin sequence length", rst_cnt, DRV + SMP);
        check(vec_sel == 3'd1, "R5 pin vector", int'(vec_sel), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_watchdog();
        t_restart();
        t_flags_cleared();
        t_power_priority();
        t_vec_hold();
        t_external_extend();
        t_idle_pin();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule